// File: doc/BRIEF.md
# NRZI 4b/5b Line Codec with Hard-Reset Detection

This block is the serial symbol layer of a clock-forwarded ring link. The transmit half accepts one symbol every five line clocks (a 4-bit data nibble or a control symbol), expands it to a 5-bit code group and drives it out one bit per clock as an NRZI waveform. In NRZI, a one bit flips the line level and a zero bit leaves the level as it was. Four payload bits ride in every five line bits, so a 40 MHz line carries at most 32 Mbit/s of data.

The receive half turns level changes back into bits. It locks onto code-group boundaries by finding a start-of-frame pair, then decodes every fifth bit into a nibble or a control symbol. Groups that are not in the code table are flagged. Alongside decoding, a run detector counts consecutive one bits. No legal code stream can produce a long run of ones, so such a run is reserved as an in-band hard-reset command. The detector raises a level output that any upstream reset logic can use at any time, not only after power-up.

Top module: `nrzi45_codec`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `lineOut`, `rxValid`, `codeError` and `hardReset` are low, `rxKind` and `rxData` are zero, and `txTake` is high.
- R2: `txTake` is high for one cycle in every five. At the edge that ends a `txTake` cycle the block samples `txKind`/`txData` and maps them to a code group. The kind codes are: 0 data, 1 J (11000), 2 K (10001), 3 T (01101), 4 R (00111), and 5 to 7 a break group (11111). The data nibbles 0..F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: Group bits go out most significant bit first, one per clock. Each bit updates `lineOut` at a clock edge: a 1 inverts it and a 0 holds it. The first bit of a group takes effect at the same edge that samples the symbol.
- R4: The receiver takes each bit as `lineIn` at the current edge XOR `lineIn` at the previous edge. The previous level counts as 0 after reset.
- R5: Before the first alignment, `rxValid` and `codeError` stay low. The receiver aligns at the edge where its last ten bits equal 11000 10001 (J then K). It aligns again whenever this pair appears. That edge yields one `rxValid` cycle with kind K, and a J that is not on an already aligned boundary is not reported.
- R6: While aligned, every fifth bit closes a group. A group found in the table gives `rxValid` for one cycle after the edge that samples its last bit. `rxKind` uses the R2 codes, and `rxData` carries the nibble for data groups and 0 otherwise. When `rxValid` is low, `rxKind` and `rxData` are 0.
- R7: An aligned group that is not in the table gives a one-cycle `codeError` pulse with `rxValid` low.
- R8: `hardReset` goes high after the edge that samples the 32nd consecutive one bit. It stays high while ones continue and goes low after the edge that samples the next zero bit. A run of 31 ones never raises it.
- R9: Raising `hardReset` drops alignment. Later groups are not reported until a new J K pair is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| txKind | input | 3 | Kind of the symbol to send (R2 codes) |
| txData | input | 4 | Nibble to send when the kind is data |
| txTake | output | 1 | Symbol sampling slot: inputs taken at the end of this cycle |
| lineOut | output | 1 | NRZI line level sent |
| lineIn | input | 1 | NRZI line level received |
| rxValid | output | 1 | One-cycle strobe for a received symbol |
| rxKind | output | 3 | Kind of the received symbol |
| rxData | output | 4 | Nibble of a received data symbol |
| codeError | output | 1 | One-cycle strobe for an undefined aligned group |
| hardReset | output | 1 | Long run of ones detected |

## Verification
In the looped-back patterns, the line is fed from the block's own transmitter. These patterns send all sixteen nibbles and every control kind. They separate correct table mapping and bit order from a design that only keeps the NRZI level right. Runs of exactly 31 and 32 ones, driven by hand onto the line, locate the hard-reset threshold. A J K pair placed three bits off the transmit boundary, followed by an all-zero group, shows that alignment follows the received stream and not the local slot counter, and that undefined groups are flagged but not delivered. Data sent before any J K pair, and data sent after a break, show that nothing is reported while the receiver is unaligned.

// File: rtl/nrzi45_pkg.sv
package nrzi45_pkg;

  localparam int NIB_W  = 4;
  localparam int GRP_W  = 5;
  localparam int PAIR_W = 2 * GRP_W;
  localparam int KIND_W = 3;
  localparam int NIB_N  = 1 << NIB_W;

  typedef enum logic [KIND_W-1:0] {
    SYM_DATA = 3'd0,
    SYM_J    = 3'd1,
    SYM_K    = 3'd2,
    SYM_T    = 3'd3,
    SYM_R    = 3'd4,
    SYM_BRK  = 3'd5
  } symKind_e;

  localparam logic [GRP_W-1:0] GRP_J   = 5'b11000;
  localparam logic [GRP_W-1:0] GRP_K   = 5'b10001;
  localparam logic [GRP_W-1:0] GRP_T   = 5'b01101;
  localparam logic [GRP_W-1:0] GRP_R   = 5'b00111;
  localparam logic [GRP_W-1:0] GRP_BRK = 5'b11111;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic rxAlignNow;
    logic rxGroupDone;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic jkSeen;
    logic breakNow;
  } rxStatus_t;

  typedef struct packed {
    logic             ok;
    symKind_e         kind;
    logic [NIB_W-1:0] nib;
  } groupInfo_t;

  function automatic logic [GRP_W-1:0] dataGroup(input logic [NIB_W-1:0] nib);
    logic [GRP_W-1:0] g;
    case (nib)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  function automatic logic [GRP_W-1:0] encodeSym(input logic [KIND_W-1:0] kind,
                                                 input logic [NIB_W-1:0] nib);
    logic [GRP_W-1:0] g;
    case (kind)
      SYM_DATA: g = dataGroup(nib);
      SYM_J:    g = GRP_J;
      SYM_K:    g = GRP_K;
      SYM_T:    g = GRP_T;
      SYM_R:    g = GRP_R;
      default:  g = GRP_BRK;
    endcase
    return g;
  endfunction

  function automatic groupInfo_t decodeGroup(input logic [GRP_W-1:0] grp);
    groupInfo_t info;
    info.ok   = 1'b0;
    info.kind = SYM_DATA;
    info.nib  = '0;
    for (int i = 0; i < NIB_N; i++) begin
      if (dataGroup(NIB_W'(i)) == grp) begin
        info.ok  = 1'b1;
        info.nib = NIB_W'(i);
      end
    end
    case (grp)
      GRP_J: begin info.ok = 1'b1; info.kind = SYM_J; end
      GRP_K: begin info.ok = 1'b1; info.kind = SYM_K; end
      GRP_T: begin info.ok = 1'b1; info.kind = SYM_T; end
      GRP_R: begin info.ok = 1'b1; info.kind = SYM_R; end
      default: ;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/nrzi45_control.sv
module nrzi45_control
  import nrzi45_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  rxStatus_t   status,
  output ctrlStrobe_t strobe
);

  localparam int SLOT_W = $clog2(GRP_W);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(GRP_W - 1);

  logic [SLOT_W-1:0] txSlot;
  logic [SLOT_W-1:0] rxPhase;
  logic              aligned;

  // transmit slot counter: one symbol every GRP_W clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      txSlot <= '0;
    end else if (txSlot == SLOT_LAST) begin
      txSlot <= '0;
    end else begin
      txSlot <= txSlot + 1'b1;
    end
  end

  // receive alignment: J K pair wins, a break drops lock
  always_ff @(posedge clk) begin
    if (rst) begin
      aligned <= 1'b0;
      rxPhase <= '0;
    end else if (status.jkSeen) begin
      aligned <= 1'b1;
      rxPhase <= '0;
    end else if (status.breakNow) begin
      aligned <= 1'b0;
      rxPhase <= '0;
    end else if (aligned) begin
      rxPhase <= (rxPhase == SLOT_LAST) ? '0 : rxPhase + 1'b1;
    end
  end

  always_comb begin
    strobe.txLoad      = (txSlot == '0);
    strobe.rxAlignNow  = status.jkSeen;
    strobe.rxGroupDone = aligned && (rxPhase == SLOT_LAST) &&
                         !status.jkSeen && !status.breakNow;
  end

  // R2
  tx_slot_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.txLoad |=> !strobe.txLoad);

  // R5
  align_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(status.jkSeen));

  // R9
  break_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (status.breakNow && !status.jkSeen) |=> !aligned);

endmodule

// File: rtl/nrzi45_datapath.sv
module nrzi45_datapath
  import nrzi45_pkg::*;
#(
  parameter int BREAK_RUN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  output rxStatus_t         status,
  input  logic [KIND_W-1:0] txKind,
  input  logic [NIB_W-1:0]  txData,
  output logic              lineOut,
  input  logic              lineIn,
  output logic              rxValid,
  output logic [KIND_W-1:0] rxKind,
  output logic [NIB_W-1:0]  rxData,
  output logic              codeError,
  output logic              hardReset
);

  localparam int RUN_W = $clog2(BREAK_RUN + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(BREAK_RUN);
  localparam logic [RUN_W-1:0]  RUN_TRIP = RUN_W'(BREAK_RUN - 1);
  localparam logic [PAIR_W-1:0] SOF_PAIR = {GRP_J, GRP_K};

  // ---------------- transmit ----------------
  logic [GRP_W-1:0] txGroup;
  logic [GRP_W-2:0] txRest;

  assign txGroup = encodeSym(txKind, txData);

  always_ff @(posedge clk) begin
    if (rst) begin
      lineOut <= 1'b0;
      txRest  <= '0;
    end else if (strobe.txLoad) begin
      lineOut <= lineOut ^ txGroup[GRP_W-1];
      txRest  <= txGroup[GRP_W-2:0];
    end else begin
      lineOut <= lineOut ^ txRest[GRP_W-2];
      txRest  <= {txRest[GRP_W-3:0], 1'b0};
    end
  end

  // ---------------- receive ----------------
  logic              prevLevel;
  logic              rxBit;
  logic [PAIR_W-2:0] rxHist;
  logic [PAIR_W-1:0] rxWin;
  logic [RUN_W-1:0]  onesRun;
  groupInfo_t        grpInfo;

  assign rxBit   = lineIn ^ prevLevel;
  assign rxWin   = {rxHist, rxBit};
  assign grpInfo = decodeGroup(rxWin[GRP_W-1:0]);

  always_comb begin
    status.jkSeen   = (rxWin == SOF_PAIR);
    status.breakNow = rxBit && (onesRun >= RUN_TRIP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLevel <= 1'b0;
      rxHist    <= '0;
      onesRun   <= '0;
      hardReset <= 1'b0;
    end else begin
      prevLevel <= lineIn;
      rxHist    <= rxWin[PAIR_W-2:0];
      if (!rxBit) begin
        onesRun <= '0;
      end else if (onesRun != RUN_MAX) begin
        onesRun <= onesRun + 1'b1;
      end
      hardReset <= status.breakNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxValid   <= 1'b0;
      rxKind    <= '0;
      rxData    <= '0;
      codeError <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      rxKind    <= '0;
      rxData    <= '0;
      codeError <= 1'b0;
      if (strobe.rxAlignNow) begin
        rxValid <= 1'b1;
        rxKind  <= SYM_K;
      end else if (strobe.rxGroupDone) begin
        if (grpInfo.ok) begin
          rxValid <= 1'b1;
          rxKind  <= grpInfo.kind;
          rxData  <= (grpInfo.kind == SYM_DATA) ? grpInfo.nib : '0;
        end else begin
          codeError <= 1'b1;
        end
      end
    end
  end

  // R7
  error_excl_chk: assert property (@(posedge clk) disable iff (rst)
    codeError |-> !rxValid);

  // R8
  reset_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
    hardReset |-> $past(rxBit));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hardReset) |=> !rxValid);

  // R6
  idle_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !rxValid |-> (rxKind == '0 && rxData == '0));

endmodule

// File: rtl/nrzi45_codec.sv
module nrzi45_codec
  import nrzi45_pkg::*;
#(
  parameter int BREAK_RUN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] txKind,
  input  logic [3:0] txData,
  output logic       txTake,
  output logic       lineOut,
  input  logic       lineIn,
  output logic       rxValid,
  output logic [2:0] rxKind,
  output logic [3:0] rxData,
  output logic       codeError,
  output logic       hardReset
);

  ctrlStrobe_t strobe;
  rxStatus_t   status;

  nrzi45_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .strobe (strobe)
  );

  nrzi45_datapath #(.BREAK_RUN(BREAK_RUN)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .status    (status),
    .txKind    (txKind),
    .txData    (txData),
    .lineOut   (lineOut),
    .lineIn    (lineIn),
    .rxValid   (rxValid),
    .rxKind    (rxKind),
    .rxData    (rxData),
    .codeError (codeError),
    .hardReset (hardReset)
  );

  assign txTake = strobe.txLoad;

endmodule

// File: tb/sim_nrzi45_codec.sv
`timescale 1ns/1ps
module sim_nrzi45_codec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0] txKind = 3'd0;
  logic [3:0] txData = 4'd0;
  logic       manual = 1'b0;
  logic       manLevel = 1'b0;
  logic       txTake, lineOut, rxValid, codeError, hardReset;
  logic [2:0] rxKind;
  logic [3:0] rxData;
  logic       lineIn;

  assign lineIn = manual ? manLevel : lineOut;

  nrzi45_codec u0 (
    .clk(clk), .rst(rst), .txKind(txKind), .txData(txData), .txTake(txTake),
    .lineOut(lineOut), .lineIn(lineIn), .rxValid(rxValid), .rxKind(rxKind),
    .rxData(rxData), .codeError(codeError), .hardReset(hardReset)
  );

  int checks = 0;
  int failures = 0;
  bit run = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------- reference tables (from R2) ----------
  function automatic int codeOf(input int kind, input int nib);
    int t;
    if (kind == 0) begin
      case (nib)
        0: t = 'b11110;  1: t = 'b01001;  2: t = 'b10100;  3: t = 'b10101;
        4: t = 'b01010;  5: t = 'b01011;  6: t = 'b01110;  7: t = 'b01111;
        8: t = 'b10010;  9: t = 'b10011; 10: t = 'b10110; 11: t = 'b10111;
        12: t = 'b11010; 13: t = 'b11011; 14: t = 'b11100; default: t = 'b11101;
      endcase
    end else if (kind == 1) t = 'b11000;
    else if (kind == 2) t = 'b10001;
    else if (kind == 3) t = 'b01101;
    else if (kind == 4) t = 'b00111;
    else t = 'b11111;
    return t;
  endfunction

  function automatic void lookup(input int g, output bit ok, output int k, output int d);
    ok = 0; k = 0; d = 0;
    for (int i = 0; i < 16; i++) if (codeOf(0, i) == g) begin ok = 1; d = i; end
    for (int j = 1; j <= 4; j++) if (codeOf(j, 0) == g) begin ok = 1; k = j; d = 0; end
  endfunction

  // ---------- behavioural reference model ----------
  int mTxCnt;
  bit mTxBits[$];
  bit mLevel, mPrev, mAligned;
  int mHist, mOnes, mPhase;
  bit eValid, eErr, eHr, eTake;
  int eKind, eData;

  always @(posedge clk) begin
    if (rst) begin
      mTxCnt = 0; mTxBits.delete(); mLevel = 0; mPrev = 0; mAligned = 0;
      mHist = 0; mOnes = 0; mPhase = 0;
      eValid = 0; eErr = 0; eHr = 0; eKind = 0; eData = 0; eTake = 1;
    end else begin
      bit b, ok;
      int g, k, d;
      // transmit
      if (mTxCnt == 0) begin
        g = codeOf(int'(txKind), int'(txData));
        for (int i = 4; i >= 0; i--) mTxBits.push_back(bit'((g >> i) & 1));
      end
      b = mTxBits.pop_front();
      mLevel = mLevel ^ b;
      mTxCnt = (mTxCnt + 1) % 5;
      eTake = (mTxCnt == 0);
      // receive
      b = lineIn ^ mPrev;
      mPrev = lineIn;
      mHist = ((mHist << 1) | int'(b)) & 'h3FF;
      mOnes = b ? mOnes + 1 : 0;
      eHr = (mOnes >= 32);
      eValid = 0; eErr = 0; eKind = 0; eData = 0;
      if (mHist == 'b1100010001) begin
        mAligned = 1; mPhase = 0; eValid = 1; eKind = 2;
      end else if (mOnes >= 32) begin
        mAligned = 0; mPhase = 0;
      end else if (mAligned) begin
        if (mPhase == 4) begin
          mPhase = 0;
          lookup(mHist & 'h1F, ok, k, d);
          if (ok) begin eValid = 1; eKind = k; eData = d; end
          else eErr = 1;
        end else mPhase++;
      end
    end
  end

  // ---------- event logs and per-cycle comparison ----------
  int rxLog[$];
  int errCnt = 0;
  int hrRise = 0;
  bit hrPrev = 0;

  always @(negedge clk) begin
    if (run) begin
      chk(txTake == eTake, "R2 txTake slot", int'(txTake), int'(eTake));
      chk(lineOut == mLevel, "R3 lineOut level", int'(lineOut), int'(mLevel));
      chk(rxValid == eValid, "R6 rxValid", int'(rxValid), int'(eValid));
      chk(int'(rxKind) == eKind, "R6 rxKind", int'(rxKind), eKind);
      chk(int'(rxData) == eData, "R4 rxData", int'(rxData), eData);
      chk(codeError == eErr, "R7 codeError", int'(codeError), int'(eErr));
      chk(hardReset == eHr, "R8 hardReset", int'(hardReset), int'(eHr));
      if (rxValid) rxLog.push_back(int'(rxKind) * 16 + int'(rxData));
      if (codeError) errCnt++;
      if (hardReset && !hrPrev) hrRise++;
      hrPrev = hardReset;
    end
  end

  // ---------- stimulus drivers ----------
  int txQ[$];     // kind*16+data
  bit lnQ[$];     // raw bits for manual line

  always @(negedge clk) begin
    if (txTake) begin
      if (txQ.size() > 0) begin
        int s;
        s = txQ.pop_front();
        txKind <= 3'(s / 16);
        txData <= 4'(s % 16);
      end else begin
        txKind <= 3'd0;
        txData <= 4'd0;
      end
    end
    if (manual && lnQ.size() > 0) manLevel <= manLevel ^ lnQ.pop_front();
  end

  task automatic pushBits(input int value, input int n);
    for (int i = n - 1; i >= 0; i--) lnQ.push_back(bit'((value >> i) & 1));
  endtask

  task automatic pushRun(input bit v, input int n);
    for (int i = 0; i < n; i++) lnQ.push_back(v);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int hr0, e0;
    bit seenHigh;
    cycles(3);
    // R1 reset state
    chk(lineOut == 0 && rxValid == 0 && codeError == 0 && hardReset == 0,
        "R1 outputs low in reset", int'({lineOut, rxValid, codeError, hardReset}), 0);
    chk(txTake == 1 && rxKind == 0 && rxData == 0, "R1 txTake/fields in reset",
        int'({txTake, rxKind, rxData}), 128);
    rst = 0;
    run = 1;

    // R5: data before any J K pair is never reported
    for (int i = 1; i <= 4; i++) txQ.push_back(i);
    cycles(40);
    chk(rxLog.size() == 0, "R5 nothing before alignment", rxLog.size(), 0);
    chk(errCnt == 0, "R5 no error before alignment", errCnt, 0);

    // R2 R4 R6: full table through loopback
    rxLog.delete();
    txQ.push_back(1 * 16); txQ.push_back(2 * 16);
    for (int i = 0; i < 16; i++) txQ.push_back(i);
    txQ.push_back(3 * 16); txQ.push_back(4 * 16);
    cycles(20 * 5 + 30);
    chk(rxLog.size() >= 19, "R6 symbol count", rxLog.size(), 19);
    if (rxLog.size() >= 19) begin
      chk(rxLog[0] == 32, "R5 alignment reports K", rxLog[0], 32);
      for (int i = 0; i < 16; i++)
        chk(rxLog[1 + i] == i, "R4 decoded nibble sequence", rxLog[1 + i], i);
      chk(rxLog[17] == 48, "R2 T symbol", rxLog[17], 48);
      chk(rxLog[18] == 64, "R2 R symbol", rxLog[18], 64);
    end

    // R8 R9: break groups through loopback
    hr0 = hrRise;
    for (int i = 0; i < 7; i++) txQ.push_back(5 * 16);
    txQ.push_back(6); txQ.push_back(7);
    seenHigh = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (hardReset) seenHigh = 1;
      if (seenHigh && !hardReset) break;
    end
    chk(hrRise == hr0 + 1, "R8 break raises hardReset", hrRise, hr0 + 1);
    chk(hardReset == 0, "R8 zero clears hardReset", int'(hardReset), 0);
    rxLog.delete();
    cycles(40);
    chk(rxLog.size() == 0, "R9 unaligned after break", rxLog.size(), 0);
    txQ.push_back(1 * 16); txQ.push_back(2 * 16); txQ.push_back(9);
    cycles(45);
    chk(rxLog.size() >= 2, "R9 realign count", rxLog.size(), 2);
    if (rxLog.size() >= 2) begin
      chk(rxLog[0] == 32, "R9 realign K", rxLog[0], 32);
      chk(rxLog[1] == 9, "R9 data after realign", rxLog[1], 9);
    end

    // R8 threshold on a hand-driven line
    @(negedge clk);
    manLevel = lineOut;
    manual = 1;
    hr0 = hrRise;
    pushRun(0, 5); pushRun(1, 31); pushRun(0, 4);
    cycles(50);
    chk(hrRise == hr0, "R8 31 ones do not trip", hrRise, hr0);
    pushRun(1, 32); pushRun(0, 4);
    cycles(45);
    chk(hrRise == hr0 + 1, "R8 32 ones trip", hrRise, hr0 + 1);

    // R5 R7: off-boundary alignment and an undefined group
    rxLog.delete();
    e0 = errCnt;
    pushBits('b101, 3);
    pushBits('b11000, 5); pushBits('b10001, 5);
    pushBits('b01011, 5); pushBits('b00000, 5); pushBits('b10110, 5);
    pushBits('b01101, 5);
    cycles(50);
    chk(rxLog.size() >= 4, "R5 off-boundary symbols", rxLog.size(), 4);
    if (rxLog.size() >= 4) begin
      chk(rxLog[0] == 32, "R5 off-boundary K", rxLog[0], 32);
      chk(rxLog[1] == 5, "R6 nibble 5", rxLog[1], 5);
      chk(rxLog[2] == 10, "R7 bad group skipped", rxLog[2], 10);
      chk(rxLog[3] == 48, "R6 T after data", rxLog[3], 48);
    end
    chk(errCnt > e0, "R7 undefined group flagged", errCnt - e0, 1);

    cycles(10);
    summary();
    $finish;
  end

endmodule